// File: doc/BRIEF.md
# Link Power State Controller

This block tracks and commands the power state of a single serial link. It holds one of six link states: the fully active state L0, the quick standby L0s, the deeper standby L1, the staging state that precedes power removal, and the two powered-down states L2 (auxiliary supply kept) and L3 (everything off). It moves between them from the power state of the attached downstream device, an idle indication from the link layer, an exit request from either side of the link, a power-down request, a main-power-off indication and an auxiliary-power flag.

Only the quick standby is entered autonomously, after the link layer has reported idle for a programmable number of consecutive cycles. The deeper standby follows the downstream device's power state, so the link never sits in a lower state than the device allows. The staging state is reached from the deeper standby when the device is fully off and a power-down request arrives. When power is then removed, the link resolves to L2 or L3 according to the auxiliary flag. When power returns, the controller goes back to L0 and raises a one-cycle retrain request. It also drives a traffic enable and a ready-for-power-removal flag from its state.

Top module: `lpm_link_ctrl`

## Requirements
- R1: `link_state` reports L0=000, L0s=001, L1=010, staging=011, L2=100, L3=101. A clock edge with `rst_n` low gives L0 with `traffic_en`=1, `retrain_req`=0 and `pwr_rm_ready`=0.
- R2: From L0, with `dev_pstate`=00, the link enters L0s on the edge that ends the Nth consecutive cycle of `link_idle`=1 and `exit_req`=0, where N is `idle_thresh`. An `idle_thresh` of 0 acts as 1. A break in the idle run restarts the count.
- R3: In L0s with `dev_pstate`=00, `link_idle`=0 or `exit_req`=1 returns the link to L0 on the next edge.
- R4: `dev_pstate` encodes 00=D0, 01=D1, 10=D2, 11=D3. Any non-zero value in L0 or L0s moves the link to L1 on the next edge. L1 is never entered while `dev_pstate` is 00.
- R5: In L1, `exit_req`=1 or `dev_pstate`=00 returns the link to L0 on the next edge.
- R6: From L1, with `dev_pstate`=11, `pwr_down_req`=1 and no `exit_req`, the link enters the staging state on the next edge. A power-down request with any other device state has no effect. `pwr_rm_ready` is high exactly in the staging state.
- R7: In the staging state, `main_pwr_off`=1 moves the link to L2 when `aux_present`=1, and to L3 otherwise.
- R8: In L2 or L3, `main_pwr_off`=0 returns the link to L0 on the next edge. `retrain_req` is high for exactly that first L0 cycle.
- R9: `traffic_en` is high only in L0.
- R10: `main_pwr_off` has no effect in L0, L0s or L1. Without power removal, the staging state returns to L0 on `exit_req` or `dev_pstate`=00, and to L1 on `dev_pstate` 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_thresh | input | CNT_W | Consecutive idle cycles needed before entering L0s |
| dev_pstate | input | 2 | Downstream device power state (00 = D0 to 11 = D3) |
| link_idle | input | 1 | Link layer reports no pending traffic |
| exit_req | input | 1 | Wake or exit request from either link partner |
| pwr_down_req | input | 1 | Request to stage the link for power removal |
| main_pwr_off | input | 1 | Main power and clock are removed |
| aux_present | input | 1 | Auxiliary power is present |
| link_state | output | 3 | Current link state code |
| traffic_en | output | 1 | Transaction and link-layer traffic allowed |
| retrain_req | output | 1 | One-cycle request for a full link initialization |
| pwr_rm_ready | output | 1 | Link is staged and ready for power removal |

## Verification
Every transition lands in `link_state` on the first clock edge after the inputs that cause it, because the state register is the only register on that path. `traffic_en` and `pwr_rm_ready` are decoded from that register and change in the same cycle. `retrain_req` is registered alongside the state, so it is high in the first L0 cycle after power returns. The bench drives inputs on the falling edge, checks its behavioural model against all four outputs 1 ns after each rising edge, and makes its scripted checks on the falling edge that follows the edge expected to cause the change.

// File: rtl/lpm_pkg.sv
// Shared definitions for the link power state controller.
// Assumes a 3-bit state code; codes 110 and 111 are illegal.
package lpm_pkg;
    localparam logic [2:0] LS_L0  = 3'b000;
    localparam logic [2:0] LS_L0S = 3'b001;
    localparam logic [2:0] LS_L1  = 3'b010;
    localparam logic [2:0] LS_RDY = 3'b011;
    localparam logic [2:0] LS_L2  = 3'b100;
    localparam logic [2:0] LS_L3  = 3'b101;

    localparam logic [1:0] DEV_D0 = 2'b00;
    localparam logic [1:0] DEV_D3 = 2'b11;
endpackage

// File: rtl/lpm_idle_timer.sv
// Counts consecutive armed cycles and flags the cycle that completes the
// programmed run. Assumes a threshold of zero means one cycle. The count
// clears whenever the arm input drops.
module lpm_idle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [CNT_W-1:0] thresh,
    output logic             expire
);
    localparam logic [CNT_W:0] ONE = 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W:0]   limit;

    // Build the effective limit and the candidate count for this cycle.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + ONE;
        limit   = (thresh == '0) ? ONE : {1'b0, thresh};
        expire  = arm && (cnt_inc >= limit);
    end

    // Advance the run length while armed, clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/lpm_state_fsm.sv
// Holds the link state register and applies the transition rules.
// Assumes all inputs are synchronous to clk. An illegal state code
// recovers to L0 and raises a retrain request.
module lpm_state_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] dev_pstate,
    input  logic       link_idle,
    input  logic       exit_req,
    input  logic       pwr_down_req,
    input  logic       main_pwr_off,
    input  logic       aux_present,
    input  logic       idle_expire,
    output logic       idle_arm,
    output logic [2:0] state_q,
    output logic       retrain_q
);
    logic [2:0] state_d;
    logic       retrain_d;
    logic       dev_on;

    // Arm the idle timer only in L0 with the device active and no wake pending.
    always_comb begin
        dev_on   = (dev_pstate == DEV_D0);
        idle_arm = (state_q == LS_L0) && dev_on && link_idle && !exit_req;
    end

    // Choose the next state and whether it requires a retrain.
    always_comb begin
        state_d   = state_q;
        retrain_d = 1'b0;
        case (state_q)
            LS_L0: begin
                if (!dev_on)          state_d = LS_L1;
                else if (idle_expire) state_d = LS_L0S;
            end
            LS_L0S: begin
                if (!dev_on)                     state_d = LS_L1;
                else if (exit_req || !link_idle) state_d = LS_L0;
            end
            LS_L1: begin
                if (dev_on || exit_req) state_d = LS_L0;
                else if ((dev_pstate == DEV_D3) && pwr_down_req) state_d = LS_RDY;
            end
            LS_RDY: begin
                if (main_pwr_off)                 state_d = aux_present ? LS_L2 : LS_L3;
                else if (dev_on || exit_req)      state_d = LS_L0;
                else if (dev_pstate != DEV_D3)    state_d = LS_L1;
            end
            LS_L2, LS_L3: begin
                if (!main_pwr_off) begin
                    state_d   = LS_L0;
                    retrain_d = 1'b1;
                end
            end
            default: begin
                state_d   = LS_L0;
                retrain_d = 1'b1;
            end
        endcase
    end

    // Register the state and the retrain pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LS_L0;
            retrain_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            retrain_q <= retrain_d;
        end
    end
endmodule

// File: rtl/lpm_out_map.sv
// Decodes the registered link state into the traffic enable and the
// power-removal ready flag. Purely combinational; assumes a legal code.
module lpm_out_map
    import lpm_pkg::*;
(
    input  logic [2:0] state,
    output logic       traffic_en,
    output logic       pwr_rm_ready
);
    // Allow traffic only when fully active; flag readiness only when staged.
    always_comb begin
        traffic_en   = (state == LS_L0);
        pwr_rm_ready = (state == LS_RDY);
    end
endmodule

// File: rtl/lpm_link_ctrl.sv
// Top of the link power state controller: the idle timer, the state
// machine and the output decode. Assumes synchronous inputs and a
// synchronous active-low reset.
module lpm_link_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] idle_thresh,
    input  logic [1:0]       dev_pstate,
    input  logic             link_idle,
    input  logic             exit_req,
    input  logic             pwr_down_req,
    input  logic             main_pwr_off,
    input  logic             aux_present,
    output logic [2:0]       link_state,
    output logic             traffic_en,
    output logic             retrain_req,
    output logic             pwr_rm_ready
);
    logic idle_arm;
    logic idle_expire;

    lpm_idle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (idle_arm),
        .thresh (idle_thresh),
        .expire (idle_expire)
    );

    lpm_state_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_pstate   (dev_pstate),
        .link_idle    (link_idle),
        .exit_req     (exit_req),
        .pwr_down_req (pwr_down_req),
        .main_pwr_off (main_pwr_off),
        .aux_present  (aux_present),
        .idle_expire  (idle_expire),
        .idle_arm     (idle_arm),
        .state_q      (link_state),
        .retrain_q    (retrain_req)
    );

    lpm_out_map u_map (
        .state        (link_state),
        .traffic_en   (traffic_en),
        .pwr_rm_ready (pwr_rm_ready)
    );
endmodule

// File: rtl/lpm_link_ctrl_chk.sv
// Property checker for the link power state controller, bound to the top.
// Assumes reset is held for at least two clock edges at start-up.
module lpm_link_ctrl_chk
    import lpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] dev_pstate,
    input logic       link_idle,
    input logic       exit_req,
    input logic       pwr_down_req,
    input logic       main_pwr_off,
    input logic       aux_present,
    input logic [2:0] link_state,
    input logic       traffic_en,
    input logic       retrain_req,
    input logic       pwr_rm_ready
);
    assert_l0s_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state != LS_L0S && !(link_state == LS_L0 && dev_pstate == DEV_D0
         && link_idle && !exit_req)) |=> link_state != LS_L0S);

    assert_l0s_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == LS_L0S && dev_pstate == DEV_D0 && (exit_req || !link_idle))
        |=> link_state == LS_L0);

    assert_l1_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state == LS_L0 || link_state == LS_L0S) && dev_pstate != DEV_D0)
        |=> link_state == LS_L1);

    assert_no_l1_in_d0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_pstate == DEV_D0) |=> link_state != LS_L1);

    assert_l1_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == LS_L1 && (exit_req || dev_pstate == DEV_D0))
        |=> link_state == LS_L0);

    assert_stage_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == LS_L1 && dev_pstate == DEV_D3 && pwr_down_req && !exit_req)
        |=> link_state == LS_RDY);

    assert_ready_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_rm_ready == (link_state == LS_RDY));

    assert_to_l2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == LS_RDY && main_pwr_off && aux_present) |=> link_state == LS_L2);

    assert_to_l3_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == LS_RDY && main_pwr_off && !aux_present) |=> link_state == LS_L3);

    assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state == LS_L2 || link_state == LS_L3) && !main_pwr_off)
        |=> (link_state == LS_L0 && retrain_req));

    assert_retrain_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_req |=> !retrain_req);

    assert_traffic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        traffic_en == (link_state == LS_L0));

    assert_off_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state == LS_L0 || link_state == LS_L0S || link_state == LS_L1) && main_pwr_off)
        |=> (link_state != LS_L2 && link_state != LS_L3));
endmodule

bind lpm_link_ctrl lpm_link_ctrl_chk u_chk (.*);

// File: tb/tb_lpm_link_ctrl.sv
module tb_lpm_link_ctrl;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] idle_thresh;
    logic [1:0]       dev_pstate;
    logic             link_idle, exit_req, pwr_down_req, main_pwr_off, aux_present;
    logic [2:0]       link_state;
    logic             traffic_en, retrain_req, pwr_rm_ready;

    int    errors = 0;
    int    checks = 0;
    bit    cmp_en = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    int m_st = 0;
    int m_cnt = 0;
    bit m_rt = 1'b0;

    lpm_link_ctrl #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .idle_thresh(idle_thresh), .dev_pstate(dev_pstate),
        .link_idle(link_idle), .exit_req(exit_req), .pwr_down_req(pwr_down_req),
        .main_pwr_off(main_pwr_off), .aux_present(aux_present), .link_state(link_state),
        .traffic_en(traffic_en), .retrain_req(retrain_req), .pwr_rm_ready(pwr_rm_ready)
    );

    always #2 clk = ~clk;

    // Behavioural reference: state numbers 0..5 follow the codes in R1.
    always @(posedge clk) begin
        int thr;
        int nst;
        bit nrt;
        thr = (idle_thresh == 0) ? 1 : int'(idle_thresh);
        nst = m_st;
        nrt = 1'b0;
        if (!rst_n) begin
            nst = 0;
            m_cnt <= 0;
        end else begin
            if (m_st == 0 && dev_pstate == 0 && link_idle && !exit_req) begin
                if (m_cnt + 1 >= thr) begin
                    nst = 1;
                    m_cnt <= 0;
                end else begin
                    m_cnt <= m_cnt + 1;
                end
            end else begin
                m_cnt <= 0;
            end
            if (m_st == 0) begin
                if (dev_pstate != 0) nst = 2;
            end else if (m_st == 1) begin
                if (dev_pstate != 0) nst = 2;
                else if (exit_req || !link_idle) nst = 0;
            end else if (m_st == 2) begin
                if (dev_pstate == 0 || exit_req) nst = 0;
                else if (dev_pstate == 3 && pwr_down_req) nst = 3;
            end else if (m_st == 3) begin
                if (main_pwr_off) nst = aux_present ? 4 : 5;
                else if (dev_pstate == 0 || exit_req) nst = 0;
                else if (dev_pstate != 3) nst = 2;
            end else begin
                if (!main_pwr_off) begin
                    nst = 0;
                    nrt = 1'b1;
                end
            end
        end
        m_st <= nst;
        m_rt <= nrt;
    end

    // Compare every output with the model just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (cmp_en && !done) begin
            checks++;
            if (link_state !== 3'(m_st) || traffic_en !== (m_st == 0) ||
                pwr_rm_ready !== (m_st == 3) || retrain_req !== m_rt) begin
                errors++;
                $display("FAIL %s: state=%b ten=%b rdy=%b rt=%b expected state=%b ten=%b rdy=%b rt=%b",
                         cur_req, link_state, traffic_en, pwr_rm_ready, retrain_req,
                         3'(m_st), (m_st == 0), (m_st == 3), m_rt);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_state(input logic [2:0] exp, input string tag);
        checks++;
        if (link_state !== exp) begin
            errors++;
            $display("FAIL %s: link_state=%b expected %b", tag, link_state, exp);
        end
    endtask

    task automatic exp_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: output=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; idle_thresh = 8'd4; dev_pstate = 2'b00; link_idle = 1'b0;
        exit_req = 1'b0; pwr_down_req = 1'b0; main_pwr_off = 1'b0; aux_present = 1'b0;
        step(3);
        cur_req = "R1";
        exp_state(3'b000, "R1");
        exp_bit(traffic_en, 1'b1, "R1 traffic_en");
        exp_bit(retrain_req, 1'b0, "R1 retrain_req");
        exp_bit(pwr_rm_ready, 1'b0, "R1 pwr_rm_ready");
        cmp_en = 1'b1;
        rst_n = 1'b1;

        cur_req = "R2";
        link_idle = 1'b1; step(3); exp_state(3'b000, "R2 short run");
        link_idle = 1'b0; step(1);
        link_idle = 1'b1; step(3); exp_state(3'b000, "R2 restarted run");
        step(1); exp_state(3'b001, "R2 entry after four");
        exp_bit(traffic_en, 1'b0, "R9 in L0s");

        cur_req = "R3";
        link_idle = 1'b0; step(1); exp_state(3'b000, "R3 idle drop");
        link_idle = 1'b1; step(4); exp_state(3'b001, "R3 re-entry");
        exit_req = 1'b1; step(1); exp_state(3'b000, "R3 exit request");
        exit_req = 1'b0; link_idle = 1'b0; step(1);

        cur_req = "R2";
        idle_thresh = 8'd0; link_idle = 1'b1; step(1); exp_state(3'b001, "R2 zero threshold");

        cur_req = "R4";
        dev_pstate = 2'b01; step(1); exp_state(3'b010, "R4 from L0s");
        exp_bit(traffic_en, 1'b0, "R9 in L1");

        cur_req = "R5";
        dev_pstate = 2'b00; link_idle = 1'b0; step(1); exp_state(3'b000, "R5 device back to D0");
        dev_pstate = 2'b10; step(1); exp_state(3'b010, "R4 from L0");
        exit_req = 1'b1; step(1); exp_state(3'b000, "R5 exit request");
        exit_req = 1'b0; step(1); exp_state(3'b010, "R4 device still D2");

        cur_req = "R6";
        pwr_down_req = 1'b1; step(2); exp_state(3'b010, "R6 request ignored in D2");
        exp_bit(pwr_rm_ready, 1'b0, "R6 not ready in L1");
        dev_pstate = 2'b11; step(1); exp_state(3'b011, "R6 staged");
        exp_bit(pwr_rm_ready, 1'b1, "R6 ready flag");
        pwr_down_req = 1'b0;

        cur_req = "R7";
        aux_present = 1'b1; main_pwr_off = 1'b1; step(1); exp_state(3'b100, "R7 to L2");
        exp_bit(pwr_rm_ready, 1'b0, "R6 ready drops");
        step(2); exp_state(3'b100, "R8 holds while off");

        cur_req = "R8";
        main_pwr_off = 1'b0; step(1); exp_state(3'b000, "R8 restore");
        exp_bit(retrain_req, 1'b1, "R8 retrain high");
        step(1); exp_bit(retrain_req, 1'b0, "R8 retrain one cycle");
        exp_state(3'b010, "R4 D3 after restore");

        cur_req = "R7";
        pwr_down_req = 1'b1; step(1); exp_state(3'b011, "R6 staged again");
        pwr_down_req = 1'b0; aux_present = 1'b0; main_pwr_off = 1'b1; step(1);
        exp_state(3'b101, "R7 to L3");
        cur_req = "R8";
        main_pwr_off = 1'b0; step(1); exp_state(3'b000, "R8 restore from L3");
        exp_bit(retrain_req, 1'b1, "R8 retrain from L3");
        step(1);

        cur_req = "R10";
        pwr_down_req = 1'b1; step(1); exp_state(3'b011, "R10 staged");
        pwr_down_req = 1'b0; dev_pstate = 2'b01; step(1); exp_state(3'b010, "R10 abort to L1");
        dev_pstate = 2'b11; pwr_down_req = 1'b1; step(1); exp_state(3'b011, "R10 staged again");
        pwr_down_req = 1'b0; exit_req = 1'b1; step(1); exp_state(3'b000, "R10 abort to L0");
        exit_req = 1'b0; dev_pstate = 2'b00; step(1);
        main_pwr_off = 1'b1; step(3); exp_state(3'b000, "R10 off ignored in L0");
        main_pwr_off = 1'b0; dev_pstate = 2'b01; step(1);
        main_pwr_off = 1'b1; step(2); exp_state(3'b010, "R10 off ignored in L1");
        main_pwr_off = 1'b0; dev_pstate = 2'b00; step(1); exp_state(3'b000, "R5 back to L0");

        cur_req = "R3 R5 R7 mixed";
        idle_thresh = 8'd3;
        for (int i = 0; i < 400; i++) begin
            link_idle    = ($urandom % 4) != 0;
            exit_req     = ($urandom % 8) == 0;
            dev_pstate   = (($urandom % 3) == 0) ? 2'($urandom % 4) : dev_pstate;
            pwr_down_req = ($urandom % 3) == 0;
            main_pwr_off = ($urandom % 4) == 0;
            aux_present  = ($urandom % 2) == 0;
            step(1);
        end
        step(2);
        finish_run();
    end
endmodule